// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor core through its power states and drives the clock enables that go with each one. It reads active-low control inputs (stop-clock, sleep and deep-sleep) and an active-high bus-clock-running flag. All four arrive asynchronously and pass through two-flop synchronizers. A block reset, `rst_n`, forces the state back to run. The enable outputs feed the real gating cells elsewhere: one for the core units, one for the bus and interrupt-controller units, and one for the PLL. The block also tells the surrounding logic whether snoops and interrupts may be taken. When the core first parks, it raises a one-cycle request for the stop acknowledge transaction.

There are four states: RUN (Normal, code 0), PARK (Stop-Grant, code 1), DOZE (Sleep, code 2) and HIBER (Deep Sleep, code 3). The named transitions are:
- `t_park`: RUN to PARK, on stop-clock asserted.
- `t_unpark`: PARK to RUN, on stop-clock deasserted.
- `t_doze`: PARK to DOZE, on sleep asserted, when stop-clock is still asserted.
- `t_wake`: DOZE to PARK, on sleep deasserted.
- `t_hiber`: DOZE to HIBER, on deep-sleep asserted or the bus clock stopped, when sleep is still asserted.
- `t_rise`: HIBER to DOZE, on deep-sleep deasserted while the bus clock runs.
- `t_reset`: any state to RUN, on reset.

Top module: `pwr_state_seq`

## Requirements
- R1: During and after reset the state is RUN (`pwr_state` = 0), all clock enables and both accept outputs are 1, and `sg_ack_req` is 0.
- R2: Asserting stop-clock (`stpclk_n`=0) in RUN moves the block to PARK (`pwr_state` = 1). `sg_ack_req` is 1 for exactly the first cycle in which PARK is shown.
- R3: In PARK, `core_clk_en`=0 while `bus_clk_en`, `pll_en`, `snoop_ok` and `intr_ok` are 1.
- R4: Deasserting stop-clock in PARK returns the block to RUN with every enable at 1.
- R5: The sleep input has no effect in any state other than PARK and DOZE. Asserting it in RUN leaves the block in RUN.
- R6: Asserting sleep (`slp_n`=0) in PARK moves the block to DOZE (`pwr_state` = 2). In DOZE only `pll_en` is 1, and the core, bus, snoop and interrupt outputs are 0.
- R7: In DOZE, a change of stop-clock has no effect on the state or the outputs.
- R8: Deasserting sleep in DOZE returns the block to PARK without a `sg_ack_req` pulse.
- R9: Asserting deep-sleep (`dpslp_n`=0) in DOZE moves the block to HIBER (`pwr_state` = 3).
- R10: `bclk_run`=0 in DOZE moves the block to HIBER.
- R11: In HIBER every enable and accept output is 0. The block leaves HIBER, to DOZE, only when deep-sleep is deasserted and `bclk_run`=1 together.
- R12: An input change made just after a rising edge shows on the state and outputs after the third following rising edge, and not before.
- R13: In RUN, the deep-sleep and bus-clock-running inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| rst_n | input | 1 | Active-low reset; forces RUN |
| stpclk_n | input | 1 | Asynchronous stop-clock request, active low |
| slp_n | input | 1 | Asynchronous sleep request, active low |
| dpslp_n | input | 1 | Asynchronous deep-sleep request, active low |
| bclk_run | input | 1 | Asynchronous flag, 1 while the bus clock toggles |
| core_clk_en | output | 1 | Clock enable for core units |
| bus_clk_en | output | 1 | Clock enable for bus and interrupt-controller units |
| pll_en | output | 1 | PLL run enable |
| sg_ack_req | output | 1 | One-cycle request to issue the stop acknowledge |
| snoop_ok | output | 1 | Snoop requests may be accepted |
| intr_ok | output | 1 | Interrupt requests may be accepted |
| pwr_state | output | 2 | Current state code (0 RUN, 1 PARK, 2 DOZE, 3 HIBER) |

## Verification
The vector table walks each state with every input that matters there and with inputs that must be ignored. Sleep is asserted in RUN, stop-clock is toggled in DOZE, and deep-sleep and a stopped bus clock are applied in RUN. These patterns separate a correctly gated transition from one that ignores the state it starts from. HIBER is tried with deep-sleep released while the bus clock is stopped, and then with both conditions met, which tells the two-condition exit apart from a single-condition one. Directed cases count the synchronizer latency edge by edge, check that the acknowledge pulse lasts one cycle and does not appear when PARK is entered from below, and check reset out of HIBER.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PARK  = 2'd1,
        ST_DOZE  = 2'd2,
        ST_HIBER = 2'd3
    } pwr_state_e;

    localparam int SYNC_STAGES_DEF = 2;
    localparam int CTRL_W          = 4;

endpackage

// File: rtl/pwr_sync_bank.sv
module pwr_sync_bank #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[LAST];
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       sleep_req,
    input  logic       deep_req,
    input  logic       bclk_ok,
    output pwr_state_e state,
    output logic       park_pulse
);
    pwr_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (stop_req)                 nxt = ST_PARK;   // t_park
            ST_PARK:  if (!stop_req)                nxt = ST_RUN;    // t_unpark
                      else if (sleep_req)           nxt = ST_DOZE;   // t_doze
            ST_DOZE:  if (!sleep_req)               nxt = ST_PARK;   // t_wake
                      else if (deep_req || !bclk_ok) nxt = ST_HIBER; // t_hiber
            ST_HIBER: if (!deep_req && bclk_ok)     nxt = ST_DOZE;   // t_rise
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RUN;                                    // t_reset
            park_pulse <= 1'b0;
        end else begin
            state      <= nxt;
            park_pulse <= (state == ST_RUN) && (nxt == ST_PARK);
        end
    end

    a_r2_ack_only_on_park_entry: assert property (@(posedge clk) disable iff (!rst_n)
        park_pulse |-> (state == ST_PARK) && ($past(state) == ST_RUN));

    a_r4_run_entered_from_park: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && ($past(state) != ST_RUN) |-> $past(state) == ST_PARK);

    a_r6_doze_entry_from_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOZE) && ($past(state) != ST_DOZE)
        |-> ($past(state) == ST_PARK) || ($past(state) == ST_HIBER));

    a_r11_hiber_entered_from_doze: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIBER) && ($past(state) != ST_HIBER) |-> $past(state) == ST_DOZE);

    a_r11_hiber_exit_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HIBER) && (state != ST_HIBER) |-> $past(!deep_req && bclk_ok));
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e state,
    output logic       core_en,
    output logic       bus_en,
    output logic       pll_en,
    output logic       snoop_ok,
    output logic       intr_ok
);
    always_comb begin
        unique case (state)
            ST_RUN:   {core_en, bus_en, pll_en, snoop_ok, intr_ok} = 5'b11111;
            ST_PARK:  {core_en, bus_en, pll_en, snoop_ok, intr_ok} = 5'b01111;
            ST_DOZE:  {core_en, bus_en, pll_en, snoop_ok, intr_ok} = 5'b00100;
            ST_HIBER: {core_en, bus_en, pll_en, snoop_ok, intr_ok} = 5'b00000;
        endcase
    end

    a_r3_core_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> bus_en && pll_en);

    a_r6_bus_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> pll_en && snoop_ok && intr_ok);
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stpclk_n,
    input  logic       slp_n,
    input  logic       dpslp_n,
    input  logic       bclk_run,
    output logic       core_clk_en,
    output logic       bus_clk_en,
    output logic       pll_en,
    output logic       sg_ack_req,
    output logic       snoop_ok,
    output logic       intr_ok,
    output logic [1:0] pwr_state
);
    localparam logic [CTRL_W-1:0] IDLE_IN = 4'b1111;

    logic [CTRL_W-1:0] raw_in;
    logic [CTRL_W-1:0] syn_in;
    pwr_state_e        st;

    assign raw_in = {stpclk_n, slp_n, dpslp_n, bclk_run};

    pwr_sync_bank #(
        .W       (CTRL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_IN)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (!syn_in[3]),
        .sleep_req  (!syn_in[2]),
        .deep_req   (!syn_in[1]),
        .bclk_ok    (syn_in[0]),
        .state      (st),
        .park_pulse (sg_ack_req)
    );

    pwr_out_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (st),
        .core_en  (core_clk_en),
        .bus_en   (bus_clk_en),
        .pll_en   (pll_en),
        .snoop_ok (snoop_ok),
        .intr_ok  (intr_ok)
    );

    assign pwr_state = st;

    a_r2_ack_is_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sg_ack_req |=> !sg_ack_req);

    a_r7_doze_ignores_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_state) == 2'd2) && $past(syn_in[2] == 1'b0) |-> pwr_state != 2'd0);
endmodule

// File: tb/pwr_state_seq_tb.sv
module pwr_state_seq_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stpclk_n = 1'b1, slp_n = 1'b1, dpslp_n = 1'b1, bclk_run = 1'b1;
    logic core_clk_en, bus_clk_en, pll_en, sg_ack_req, snoop_ok, intr_ok;
    logic [1:0] pwr_state;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_seq u_dut (
        .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n),
        .dpslp_n(dpslp_n), .bclk_run(bclk_run), .core_clk_en(core_clk_en),
        .bus_clk_en(bus_clk_en), .pll_en(pll_en), .sg_ack_req(sg_ack_req),
        .snoop_ok(snoop_ok), .intr_ok(intr_ok), .pwr_state(pwr_state)
    );

    // [15]stpclk_n [14]slp_n [13]dpslp_n [12]bclk_run [11:10]state
    // [9:5] core,bus,pll,snoop,intr  [4] ack  [3:0] requirement number
    localparam logic [15:0] VEC [NVEC] = '{
        16'b1011_00_11111_0_0101, // R5 sleep in RUN ignored
        16'b0111_01_01111_1_0010, // R2 R3 park with ack
        16'b1111_00_11111_0_0100, // R4 unpark
        16'b0111_01_01111_1_0011, // R3 park again
        16'b0011_10_00100_0_0110, // R6 doze
        16'b1011_10_00100_0_0111, // R7 stop released in DOZE ignored
        16'b0111_01_01111_0_1000, // R8 wake to PARK, no ack
        16'b0011_10_00100_0_0110, // R6 doze again
        16'b0001_11_00000_0_1001, // R9 deep-sleep to HIBER
        16'b0010_11_00000_0_1011, // R11 deep released, bus clock stopped: stay
        16'b0011_10_00100_0_1011, // R11 both met: rise to DOZE
        16'b0010_11_00000_0_1010, // R10 bus clock stop to HIBER
        16'b0011_10_00100_0_1011, // R11 rise again
        16'b0111_01_01111_0_1000, // R8 wake
        16'b1111_00_11111_0_0100, // R4 back to RUN
        16'b1100_00_11111_0_1101  // R13 deep and bus stop ignored in RUN
    };

    function automatic logic [6:0] obs();
        return {pwr_state, core_clk_en, bus_clk_en, pll_en, snoop_ok, intr_ok};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [3:0] v);
        {stpclk_n, slp_n, dpslp_n, bclk_run} = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1", {1'b0, obs()}, {1'b0, 7'b00_11111});
        check("R1", {7'b0, sg_ack_req}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {1'b0, obs()}, {1'b0, 7'b00_11111});

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][15:12]);
            repeat (3) @(negedge clk);
            check($sformatf("R%0d", VEC[i][3:0]), {1'b0, obs()}, {1'b0, VEC[i][11:5]});
            check($sformatf("R%0d", VEC[i][3:0]), {7'b0, sg_ack_req}, {7'b0, VEC[i][4]});
            @(negedge clk);
            check("R2", {7'b0, sg_ack_req}, 8'h00);
        end

        // R12: latency of three rising edges
        drive(4'b0111);
        repeat (2) @(negedge clk);
        check("R12", {6'b0, pwr_state}, 8'h00);
        @(negedge clk);
        check("R12", {6'b0, pwr_state}, 8'h01);
        check("R2", {7'b0, sg_ack_req}, 8'h01);
        @(negedge clk);
        check("R2", {7'b0, sg_ack_req}, 8'h00);

        // R1: reset out of HIBER
        drive(4'b0011);
        repeat (4) @(negedge clk);
        drive(4'b0001);
        repeat (4) @(negedge clk);
        check("R9", {6'b0, pwr_state}, 8'h03);
        rst_n = 1'b0;
        drive(4'b1111);
        @(negedge clk);
        check("R1", {1'b0, obs()}, {1'b0, 7'b00_11111});
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", {1'b0, obs()}, {1'b0, 7'b00_11111});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule